// File: doc/BRIEF.md
# Strap-Addressed I2C Register Slave

This block is the two-wire serial front end of a peripheral. It brings the bus clock and data lines into the system clock domain through two-flop synchronizers and finds START and STOP conditions and clock edges. It runs the byte protocol and acknowledges by pulling the data line low. It never drives the line high. The system clock must run at least eight times faster than the bus clock.

The 7-bit slave address has three fixed upper bits, `101`. The four lower bits come from two strap pins. Each strap pin may be wired to ground, to supply, to the bus data line or to the bus clock line, which gives sixteen addresses. The block finds out how each pin is wired during the first START after reset. It samples each pin three times: while the bus idles, at the START edge, and at the first clock fall that follows. It then keeps the result as a 2-bit code per pin.

A write loads a register pointer from its first byte. Each later byte leaves on the register write port and advances the pointer. A read fetches bytes from the register read port at the pointer and sends them MSB first while the master keeps acknowledging.

Top module: `i2c_strap_slave`

## Requirements
- R1: After reset, `sdaDriveLow`, `regWrEn` and `regRdEn` are all 0.
- R2: The slave address is {`101`, code of `strapIn[1]`, code of `strapIn[0]`}, with codes ground=00, supply=01, data line=10, clock line=11. The codes are fixed at the first START after reset, and no acknowledge is given before that.
- R3: When the address byte matches and its R/W bit (bit 0 of the byte) is 0 or 1, the slave holds SDA low for the whole high phase of the ninth clock.
- R4: When the address byte does not match, SDA stays released for the rest of the transaction: no acknowledge, no write pulse and no read data.
- R5: In a write, the first byte after the address loads the 8-bit pointer. Each later byte gives one single-cycle `regWrEn` pulse carrying the pointer and the byte. The pointer then increments modulo 256.
- R6: In a read, each byte is `regRdData` fetched at the pointer (the fetch is a one-cycle `regRdEn` pulse) and is sent MSB first. The pointer increments after each fetch. Sending continues while the master acknowledges and ends at a master not-acknowledge.
- R7: A repeated START restarts the address phase and keeps the pointer, so a pointer write followed by a repeated START and a read returns data from that pointer.
- R8: A STOP releases SDA and ends the transaction. Clocked bytes that follow without a START get no acknowledge and cause no write.
- R9: The slave changes SDA only while the synchronized SCL is low, except for releasing it at START or STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the bus clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Bus clock line level |
| sdaIn | input | 1 | Bus data line level |
| sdaDriveLow | output | 1 | 1 pulls the data line low, 0 releases it |
| strapIn | input | 2 | Levels seen on the two address strap pins |
| regWrEn | output | 1 | Single-cycle register write strobe |
| regWrAddr | output | 8 | Register write address |
| regWrData | output | 8 | Register write data |
| regRdEn | output | 1 | Single-cycle register fetch strobe |
| regRdAddr | output | 8 | Register read address (current pointer) |
| regRdData | input | 8 | Register read data, valid in the fetch cycle |

## Verification
A change on the bus reaches the control logic two system clocks after it happens, through the synchronizer. The edge is then decoded in the next cycle. So SDA driving, the fetch strobe and the write pulse all appear at about the third system clock after the SCL edge that causes them. The bench model of the master waits a quarter bus period (10 system clocks) after each SCL edge before it samples. It looks at the acknowledge both early and late in the ninth high phase, and at read data in the middle of each high phase. Write pulses are compared from a scoreboard queue as they appear, and any pulse that arrives without an expected entry is a failure.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
  localparam int BYTE_W  = 8;
  localparam int ADDR_W  = 7;
  localparam int STRAP_N = 2;
  localparam int HI_W    = ADDR_W - 2 * STRAP_N;

  typedef enum logic [1:0] {
    STRAP_GND = 2'b00,
    STRAP_VCC = 2'b01,
    STRAP_SDA = 2'b10,
    STRAP_SCL = 2'b11
  } strap_code_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RX,
    ST_TX,
    ST_SKIP
  } link_state_e;

  typedef struct packed {
    logic shiftIn;
    logic loadPtr;
    logic wrStrobe;
    logic rdLoad;
    logic txShift;
    logic driveAck;
    logic releaseSda;
  } dp_strobe_t;
endpackage

// File: rtl/i2cs_sampler.sv
module i2cs_sampler #(
  parameter int SYNC_STAGES = 2,
  parameter int N_STRAP     = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sclIn,
  input  logic               sdaIn,
  input  logic [N_STRAP-1:0] strapIn,
  output logic               sclS,
  output logic               sdaS,
  output logic [N_STRAP-1:0] strapS,
  output logic               sclRise,
  output logic               sclFall,
  output logic               startDet,
  output logic               stopDet
);
  localparam int W = 2 + N_STRAP;
  localparam logic [W-1:0] RST_VAL = {{N_STRAP{1'b0}}, 2'b11};

  logic [W-1:0] rawVec;
  logic [W-1:0] syncOut;
  logic         sclP, sdaP;

  assign rawVec = {strapIn, sdaIn, sclIn};

  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
    logic [W-1:0] q;
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) q <= RST_VAL;
        else       q <= rawVec;
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) q <= RST_VAL;
        else       q <= g_sync[g-1].q;
    end
  end

  assign syncOut = g_sync[SYNC_STAGES-1].q;
  assign sclS    = syncOut[0];
  assign sdaS    = syncOut[1];
  assign strapS  = syncOut[W-1:2];

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      sclP <= 1'b1;
      sdaP <= 1'b1;
    end else begin
      sclP <= sclS;
      sdaP <= sdaS;
    end

  assign sclRise  = sclS & ~sclP;
  assign sclFall  = ~sclS & sclP;
  assign startDet = sclS & sclP & sdaP & ~sdaS;
  assign stopDet  = sclS & sclP & ~sdaP & sdaS;
endmodule

// File: rtl/i2cs_strap_decoder.sv
module i2cs_strap_decoder
  import i2cs_pkg::*;
#(
  parameter int N_STRAP = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 sclS,
  input  logic                 sdaS,
  input  logic [N_STRAP-1:0]   strapS,
  input  logic                 startDet,
  input  logic                 sclFall,
  output logic [2*N_STRAP-1:0] strapCodes,
  output logic                 locked
);
  logic armed;

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      armed  <= 1'b0;
      locked <= 1'b0;
    end else if (!locked) begin
      if (!armed && startDet)    armed  <= 1'b1;
      else if (armed && sclFall) locked <= 1'b1;
    end

  for (genvar g = 0; g < N_STRAP; g++) begin : g_pin
    logic        idleLvl, startLvl, lowLvl;
    strap_code_e code;

    always_ff @(posedge clk or negedge rstN)
      if (!rstN) begin
        idleLvl  <= 1'b0;
        startLvl <= 1'b0;
        lowLvl   <= 1'b0;
      end else if (!locked) begin
        if (!armed && sclS && sdaS) idleLvl  <= strapS[g];
        if (!armed && startDet)     startLvl <= strapS[g];
        if (armed && sclFall)       lowLvl   <= strapS[g];
      end

    always_comb begin
      if (!idleLvl)      code = STRAP_GND;
      else if (!startLvl) code = STRAP_SDA;
      else if (lowLvl)   code = STRAP_VCC;
      else               code = STRAP_SCL;
    end

    assign strapCodes[2*g +: 2] = code;
  end
endmodule

// File: rtl/i2cs_ctrl.sv
module i2cs_ctrl
  import i2cs_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclRise,
  input  logic       sclFall,
  input  logic       startDet,
  input  logic       stopDet,
  input  logic       sdaS,
  input  logic       addrHit,
  input  logic       rwBit,
  output dp_strobe_t strb
);
  localparam logic [3:0] LAST_BIT = 4'd8;

  link_state_e st;
  logic [3:0]  bitCnt;
  logic [1:0]  byteIdx;
  logic        ackPhase, isRead, masterNack;
  logic        rxByteDone;

  assign rxByteDone = (st == ST_RX) && !ackPhase && sclFall && (bitCnt == LAST_BIT);

  always_comb begin
    strb = '0;
    if (startDet || stopDet) begin
      strb.releaseSda = 1'b1;
    end else begin
      case (st)
        ST_RX: begin
          if (!ackPhase) begin
            if (sclRise && bitCnt < LAST_BIT) strb.shiftIn = 1'b1;
            if (rxByteDone) begin
              case (byteIdx)
                2'd0:    strb.driveAck = addrHit;
                2'd1:    begin strb.loadPtr  = 1'b1; strb.driveAck = 1'b1; end
                default: begin strb.wrStrobe = 1'b1; strb.driveAck = 1'b1; end
              endcase
            end
          end else if (sclFall) begin
            if (isRead) strb.rdLoad     = 1'b1;
            else        strb.releaseSda = 1'b1;
          end
        end
        ST_TX: begin
          if (!ackPhase) begin
            if (sclFall && bitCnt == LAST_BIT)   strb.releaseSda = 1'b1;
            else if (sclFall && bitCnt != 4'd0) strb.txShift    = 1'b1;
          end else if (sclFall && !masterNack) begin
            strb.rdLoad = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      st         <= ST_IDLE;
      bitCnt     <= '0;
      byteIdx    <= '0;
      ackPhase   <= 1'b0;
      isRead     <= 1'b0;
      masterNack <= 1'b0;
    end else if (startDet) begin
      st         <= ST_RX;
      bitCnt     <= '0;
      byteIdx    <= '0;
      ackPhase   <= 1'b0;
      isRead     <= 1'b0;
      masterNack <= 1'b0;
    end else if (stopDet) begin
      st       <= ST_IDLE;
      ackPhase <= 1'b0;
    end else begin
      case (st)
        ST_RX: begin
          if (!ackPhase) begin
            if (strb.shiftIn) bitCnt <= bitCnt + 4'd1;
            if (rxByteDone) begin
              if (byteIdx == 2'd0 && !addrHit) begin
                st <= ST_SKIP;
              end else begin
                ackPhase <= 1'b1;
                if (byteIdx == 2'd0) isRead  <= rwBit;
                if (byteIdx != 2'd2) byteIdx <= byteIdx + 2'd1;
              end
            end
          end else if (sclFall) begin
            ackPhase <= 1'b0;
            bitCnt   <= '0;
            if (isRead) st <= ST_TX;
          end
        end
        ST_TX: begin
          if (!ackPhase) begin
            if (sclRise && bitCnt < LAST_BIT) bitCnt <= bitCnt + 4'd1;
            if (sclFall && bitCnt == LAST_BIT) begin
              ackPhase   <= 1'b1;
              masterNack <= 1'b0;
            end
          end else begin
            if (sclRise) masterNack <= sdaS;
            if (sclFall) begin
              ackPhase <= 1'b0;
              bitCnt   <= '0;
              if (masterNack) st <= ST_SKIP;
            end
          end
        end
        default: ;
      endcase
    end
endmodule

// File: rtl/i2cs_datapath.sv
module i2cs_datapath
  import i2cs_pkg::*;
#(
  parameter int              PTR_W   = 8,
  parameter logic [HI_W-1:0] ADDR_HI = 3'b101
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  dp_strobe_t           strb,
  input  logic                 sdaS,
  input  logic [2*STRAP_N-1:0] strapCodes,
  input  logic                 locked,
  input  logic [BYTE_W-1:0]    regRdData,
  output logic                 addrHit,
  output logic                 rwBit,
  output logic                 sdaLow,
  output logic                 regWrEn,
  output logic [PTR_W-1:0]     regWrAddr,
  output logic [BYTE_W-1:0]    regWrData,
  output logic                 regRdEn,
  output logic [PTR_W-1:0]     regRdAddr
);
  logic [BYTE_W-1:0] rxShift, txShift;
  logic [PTR_W-1:0]  ptr;
  logic [ADDR_W-1:0] myAddr;

  assign myAddr    = {ADDR_HI, strapCodes};
  assign addrHit   = locked && (rxShift[BYTE_W-1:1] == myAddr);
  assign rwBit     = rxShift[0];
  assign regRdEn   = strb.rdLoad;
  assign regRdAddr = ptr;

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      rxShift   <= '0;
      txShift   <= '0;
      ptr       <= '0;
      sdaLow    <= 1'b0;
      regWrEn   <= 1'b0;
      regWrAddr <= '0;
      regWrData <= '0;
    end else begin
      regWrEn <= strb.wrStrobe;
      if (strb.shiftIn) rxShift <= {rxShift[BYTE_W-2:0], sdaS};

      if (strb.loadPtr) ptr <= PTR_W'(rxShift);
      else if (strb.wrStrobe || strb.rdLoad) ptr <= ptr + 1'b1;

      if (strb.wrStrobe) begin
        regWrAddr <= ptr;
        regWrData <= rxShift;
      end

      if (strb.rdLoad)       txShift <= regRdData;
      else if (strb.txShift) txShift <= {txShift[BYTE_W-2:0], 1'b0};

      if (strb.releaseSda)    sdaLow <= 1'b0;
      else if (strb.driveAck) sdaLow <= 1'b1;
      else if (strb.rdLoad)   sdaLow <= ~regRdData[BYTE_W-1];
      else if (strb.txShift)  sdaLow <= ~txShift[BYTE_W-2];
    end
endmodule

// File: rtl/i2c_strap_slave.sv
module i2c_strap_slave
  import i2cs_pkg::*;
#(
  parameter int              SYNC_STAGES = 2,
  parameter logic [HI_W-1:0] ADDR_HI     = 3'b101
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sclIn,
  input  logic               sdaIn,
  output logic               sdaDriveLow,
  input  logic [STRAP_N-1:0] strapIn,
  output logic               regWrEn,
  output logic [BYTE_W-1:0]  regWrAddr,
  output logic [BYTE_W-1:0]  regWrData,
  output logic               regRdEn,
  output logic [BYTE_W-1:0]  regRdAddr,
  input  logic [BYTE_W-1:0]  regRdData
);
  logic                 sclS, sdaS, sclRise, sclFall, startDet, stopDet;
  logic [STRAP_N-1:0]   strapS;
  logic [2*STRAP_N-1:0] strapCodes;
  logic                 addrLocked, addrHit, rwBit;
  dp_strobe_t           strb;

  i2cs_sampler #(.SYNC_STAGES(SYNC_STAGES), .N_STRAP(STRAP_N)) u_sampler (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .strapIn(strapIn),
    .sclS(sclS), .sdaS(sdaS), .strapS(strapS), .sclRise(sclRise),
    .sclFall(sclFall), .startDet(startDet), .stopDet(stopDet)
  );

  i2cs_strap_decoder #(.N_STRAP(STRAP_N)) u_strap (
    .clk(clk), .rstN(rstN), .sclS(sclS), .sdaS(sdaS), .strapS(strapS),
    .startDet(startDet), .sclFall(sclFall), .strapCodes(strapCodes),
    .locked(addrLocked)
  );

  i2cs_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet), .sdaS(sdaS), .addrHit(addrHit),
    .rwBit(rwBit), .strb(strb)
  );

  i2cs_datapath #(.PTR_W(BYTE_W), .ADDR_HI(ADDR_HI)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .sdaS(sdaS), .strapCodes(strapCodes),
    .locked(addrLocked), .regRdData(regRdData), .addrHit(addrHit),
    .rwBit(rwBit), .sdaLow(sdaDriveLow), .regWrEn(regWrEn),
    .regWrAddr(regWrAddr), .regWrData(regWrData), .regRdEn(regRdEn),
    .regRdAddr(regRdAddr)
  );
endmodule

// File: rtl/i2cs_checker.sv
module i2cs_checker (
  input logic clk,
  input logic rstN,
  input logic sdaDriveLow,
  input logic regWrEn,
  input logic regRdEn,
  input logic sclS,
  input logic startDet,
  input logic stopDet,
  input logic addrLocked
);
  p_no_ack_unlocked_r2: assert property (@(posedge clk) disable iff (!rstN)
    !addrLocked |-> !sdaDriveLow);

  p_single_write_pulse_r5: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |=> !regWrEn);

  p_fetch_scl_low_r6: assert property (@(posedge clk) disable iff (!rstN)
    regRdEn |-> !sclS);

  p_release_on_start_r7: assert property (@(posedge clk) disable iff (!rstN)
    startDet |=> !sdaDriveLow);

  p_release_on_stop_r8: assert property (@(posedge clk) disable iff (!rstN)
    stopDet |=> !sdaDriveLow);

  p_sda_moves_scl_low_r9: assert property (@(posedge clk) disable iff (!rstN)
    ($changed(sdaDriveLow) && !$past(stopDet) && !$past(startDet)) |-> !sclS);
endmodule

bind i2c_strap_slave i2cs_checker u_chk (
  .clk(clk), .rstN(rstN), .sdaDriveLow(sdaDriveLow), .regWrEn(regWrEn),
  .regRdEn(regRdEn), .sclS(sclS), .startDet(startDet), .stopDet(stopDet),
  .addrLocked(addrLocked)
);

// File: tb/sim_i2c_strap_slave.sv
`timescale 1ns/1ps
module sim_i2c_strap_slave;
  localparam int Q = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       sclM = 1'b1, sdaM = 1'b1;
  logic       sdaDriveLow, regWrEn, regRdEn;
  logic [7:0] regWrAddr, regWrData, regRdAddr, regRdData;
  logic [1:0] strapPin;
  logic [1:0] sel0 = 2'd3, sel1 = 2'd0;
  logic       sdaBus;
  int         checkCnt = 0, failCnt = 0;
  bit         finished = 0;
  logic [15:0] expQ[$];

  always #5 clk = ~clk;

  assign sdaBus    = sdaM & ~sdaDriveLow;
  assign regRdData = regRdAddr ^ 8'h5A;

  function automatic logic pinLevel(input logic [1:0] s);
    case (s)
      2'd0: return 1'b0;
      2'd1: return 1'b1;
      2'd2: return sdaBus;
      default: return sclM;
    endcase
  endfunction

  always_comb begin
    strapPin[0] = pinLevel(sel0);
    strapPin[1] = pinLevel(sel1);
  end

  i2c_strap_slave u0 (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaBus),
    .sdaDriveLow(sdaDriveLow), .strapIn(strapPin), .regWrEn(regWrEn),
    .regWrAddr(regWrAddr), .regWrData(regWrData), .regRdEn(regRdEn),
    .regRdAddr(regRdAddr), .regRdData(regRdData)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checkCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor: every write pulse must match the oldest expected item (R5)
  always @(negedge clk) begin
    if (rstN && regWrEn) begin
      if (expQ.size() == 0) begin
        check(0, "R5/R4/R8 unexpected write", {regWrAddr, regWrData}, 0);
      end else begin
        automatic logic [15:0] e = expQ.pop_front();
        check({regWrAddr, regWrData} == e, "R5 write item", {regWrAddr, regWrData}, e);
      end
    end
  end

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busStart();
    sdaM = 1'b1; waitN(Q);
    sclM = 1'b1; waitN(2*Q);
    sdaM = 1'b0; waitN(2*Q);
    sclM = 1'b0; waitN(Q);
  endtask

  task automatic busStop();
    sdaM = 1'b0; waitN(Q);
    sclM = 1'b1; waitN(2*Q);
    sdaM = 1'b1; waitN(2*Q);
  endtask

  task automatic sendByte(input logic [7:0] b, output bit ack);
    bit a1, a2;
    for (int i = 7; i >= 0; i--) begin
      sdaM = b[i]; waitN(Q);
      sclM = 1'b1; waitN(2*Q);
      sclM = 1'b0; waitN(Q);
    end
    sdaM = 1'b1; waitN(Q);
    sclM = 1'b1; waitN(3);
    a1 = !sdaBus; waitN(2*Q - 4);
    a2 = !sdaBus; waitN(1);
    sclM = 1'b0; waitN(Q);
    check(a1 == a2, "R9 ack steady over high phase", a1, a2);
    ack = a1 & a2;
  endtask

  task automatic readByte(input bit giveAck, output logic [7:0] d);
    sdaM = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      waitN(Q); sclM = 1'b1;
      waitN(Q); d[i] = sdaBus;
      waitN(Q); sclM = 1'b0;
      waitN(Q);
    end
    sdaM = giveAck ? 1'b0 : 1'b1; waitN(Q);
    sclM = 1'b1; waitN(2*Q);
    sclM = 1'b0; waitN(Q);
    sdaM = 1'b1;
  endtask

  task automatic doReset(input logic [1:0] s0, input logic [1:0] s1);
    rstN = 1'b0; sclM = 1'b1; sdaM = 1'b1; sel0 = s0; sel1 = s1;
    waitN(5);
    rstN = 1'b1;
    waitN(20);
  endtask

  task automatic writeSeq(input logic [7:0] adr, input logic [7:0] ptr,
                          input logic [7:0] d0, input logic [7:0] d1, input string req);
    bit ack;
    busStart();
    sendByte({adr[6:0], 1'b0}, ack); check(ack, {req, " addr ack R3"}, ack, 1);
    sendByte(ptr, ack);              check(ack, {req, " ptr ack R5"}, ack, 1);
    expQ.push_back({ptr, d0});
    sendByte(d0, ack);               check(ack, {req, " data ack R5"}, ack, 1);
    expQ.push_back({ptr + 8'd1, d1});
    sendByte(d1, ack);               check(ack, {req, " data ack R5"}, ack, 1);
    busStop();
  endtask

  initial begin
    bit ack;
    logic [7:0] d;
    // strapIn[0] on clock line (11), strapIn[1] on ground (00): address 0x53
    doReset(2'd3, 2'd0);
    check(sdaDriveLow == 1'b0, "R1 sda released", sdaDriveLow, 0);
    check(regWrEn == 1'b0, "R1 no write", regWrEn, 0);
    check(regRdEn == 1'b0, "R1 no fetch", regRdEn, 0);

    // R2 / R3 / R5: write two bytes
    writeSeq(7'h53, 8'h10, 8'hC3, 8'h7E, "R2");
    // R5: pointer wraps from 0xFF to 0x00
    writeSeq(7'h53, 8'hFF, 8'h11, 8'h22, "R5 wrap");

    // R7: set pointer, repeated START, then read (R6)
    busStart();
    sendByte(8'hA6, ack); check(ack, "R7 addr ack", ack, 1);
    sendByte(8'h20, ack); check(ack, "R7 ptr ack", ack, 1);
    busStart();
    sendByte(8'hA7, ack); check(ack, "R3 read addr ack", ack, 1);
    readByte(1, d); check(d == (8'h20 ^ 8'h5A), "R7 first read byte", d, 8'h20 ^ 8'h5A);
    readByte(1, d); check(d == (8'h21 ^ 8'h5A), "R6 second byte", d, 8'h21 ^ 8'h5A);
    readByte(0, d); check(d == (8'h22 ^ 8'h5A), "R6 last byte", d, 8'h22 ^ 8'h5A);
    busStop();
    check(sdaBus == 1'b1, "R8 line free after stop", sdaBus, 1);

    // R6: pointer kept incrementing across the NACKed byte
    busStart();
    sendByte(8'hA7, ack); check(ack, "R6 read addr ack", ack, 1);
    readByte(0, d); check(d == (8'h23 ^ 8'h5A), "R6 pointer continues", d, 8'h23 ^ 8'h5A);
    busStop();

    // R4: other address, write then read
    busStart();
    sendByte(8'hA4, ack); check(!ack, "R4 no ack wrong addr", ack, 0);
    sendByte(8'h40, ack); check(!ack, "R4 no ack ptr", ack, 0);
    sendByte(8'h99, ack); check(!ack, "R4 no ack data", ack, 0);
    busStop();
    busStart();
    sendByte(8'hA5, ack); check(!ack, "R4 no ack read addr", ack, 0);
    readByte(0, d); check(d == 8'hFF, "R4 line stays released", d, 8'hFF);
    busStop();

    // R8: a byte clocked after STOP without START
    sclM = 1'b0; waitN(Q);
    sendByte(8'hA6, ack); check(!ack, "R8 ignored after stop", ack, 0);
    sendByte(8'h55, ack); check(!ack, "R8 ignored data", ack, 0);
    waitN(Q);

    // still functional afterwards
    writeSeq(7'h53, 8'h30, 8'hA5, 8'h5A, "R8 recover");

    // R2: strapIn[0] on data line (10), strapIn[1] on supply (01): address 0x56
    doReset(2'd2, 2'd1);
    busStart();
    sendByte(8'hA6, ack); check(!ack, "R2 old address rejected", ack, 0);
    busStop();
    writeSeq(7'h56, 8'h05, 8'h3C, 8'h81, "R2 second strap set");
    busStart();
    sendByte(8'hAC, ack); check(ack, "R2 addr ack", ack, 1);
    sendByte(8'h06, ack); check(ack, "R7 ptr ack", ack, 1);
    busStart();
    sendByte(8'hAD, ack); check(ack, "R2 read addr ack", ack, 1);
    readByte(0, d); check(d == (8'h06 ^ 8'h5A), "R6 read after restart", d, 8'h06 ^ 8'h5A);
    busStop();

    waitN(20);
    check(expQ.size() == 0, "R5 all writes seen", expQ.size(), 0);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checkCnt++;
      failCnt++;
      $display("FAIL watchdog R1-all actual=timeout expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
      $finish;
    end
  end
endmodule